// File: doc/BRIEF.md
# Store Merge Buffer with Load Forwarding

The block sits between a write-through cache and the next memory level. It takes in store words, each with a byte-enable mask, and keeps them in a small queue of line-sized slots. Each slot records which of its bytes are valid. A store to a line that already has a slot open for merging is folded into that slot. A byte written twice keeps only the newer value. So many scattered stores leave the block as a few line-wide transactions.

Every load that misses the cache probes the block first. If the buffered bytes cover all the bytes the load asks for, the block returns them in the same cycle. If the line is buffered but some requested bytes are missing, the block raises a stall until those slots have drained. Slots drain to the next level oldest first, over a valid/ready handshake. A drain starts only while the next level reports no pending read. Once started, the offer is held until it is accepted.

Top module: `store_merge_buf`

## Requirements
- R1: After reset the buffer is empty: `dr_valid` is low, `st_ready` is high for any address, and a load probe raises neither `ld_hit` nor `ld_stall`.
- R2: The line index is `st_addr[31:5]` and the word within the line is `st_addr[4:2]`. Store byte lane k is bits 8k+7:8k of `st_data`. It lands at line byte j = 4*word + k, which is bits 8j+7:8j of `dr_data` and bit j of `dr_mask`. A store to a line with no open slot takes a new slot, whose mask holds only the enabled bytes.
- R3: A store to a line that already has an open slot merges into that slot. The drain carries one transaction with the union of the byte masks.
- R4: A store to a byte that is already buffered replaces that byte's data and does not take a new slot.
- R5: The load outputs are combinational. A load probe whose enabled bytes are all buffered raises `ld_hit`. On `ld_data`, each enabled byte comes from the newest slot holding it, and each byte that is not supplied reads as zero.
- R6: A probe that matches a buffered line but finds some enabled bytes missing raises `ld_stall` with `ld_hit` low. This holds until no slot for that line remains.
- R7: A probe whose line is not buffered raises neither `ld_hit` nor `ld_stall`, and `ld_data` is zero.
- R8: A drain offer starts only while `rd_busy` is low. Once `dr_valid` is high, it stays high with an unchanged `dr_line` and `dr_mask` until `dr_ready` is seen, even if `rd_busy` rises.
- R9: Slots drain in the order they were allocated.
- R10: The slot being offered for drain accepts no merges. A store to its line takes a new slot that drains afterwards, and a load sees the newer bytes over the older ones.
- R11: With all four slots in use, `st_ready` is low for a store whose line has no open slot. It is high for a store that can merge. It rises again once a slot drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | 32 | Store byte address (word aligned) |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Store byte enables |
| ld_valid | input | 1 | Load probe request |
| ld_addr | input | 32 | Load address |
| ld_be | input | 4 | Bytes the load needs |
| ld_hit | output | 1 | All needed bytes are buffered |
| ld_stall | output | 1 | Line is buffered, some needed bytes are missing |
| ld_data | output | 32 | Forwarded bytes, zero where not supplied |
| rd_busy | input | 1 | Next level has a read pending |
| dr_valid | output | 1 | Drain transaction offered |
| dr_ready | input | 1 | Next level accepts the drain |
| dr_line | output | 27 | Line index of the drained slot |
| dr_data | output | 256 | Line data of the drained slot |
| dr_mask | output | 32 | Byte-valid mask of the drained slot |

## Verification
The hardest state to reach is two slots for the same line. This arises only when a store for that line arrives while the older slot is already being offered for drain. The bench holds `dr_ready` low with `rd_busy` low so that the offer starts and stays pending. It then stores to the same line and probes a load across both slots before releasing the two drains one at a time. A second hard state is a full buffer while the head is locked. The bench reaches it by holding `rd_busy` high while it fills all four slots, then starting and freezing the drain.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int ADDR_W  = 32;
  localparam int LINE_B  = 32;
  localparam int WORD_B  = 4;
  localparam int OFF_W   = $clog2(LINE_B);
  localparam int LANE_W  = $clog2(WORD_B);
  localparam int WSEL_W  = OFF_W - LANE_W;
  localparam int LINE_W  = ADDR_W - OFF_W;

  typedef logic [LINE_W-1:0]     line_t;
  typedef logic [LINE_B*8-1:0]   ldata_t;
  typedef logic [LINE_B-1:0]     lmask_t;
  typedef logic [WORD_B*8-1:0]   word_t;
  typedef logic [WORD_B-1:0]     be_t;
  typedef logic [WSEL_W-1:0]     wsel_t;

  function automatic line_t line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic wsel_t word_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:LANE_W];
  endfunction

  // place a word's byte enables at its slot in the line mask
  function automatic lmask_t spread_be(input wsel_t w, input be_t be);
    lmask_t m;
    m = '0;
    m[w*WORD_B +: WORD_B] = be;
    return m;
  endfunction

  function automatic ldata_t spread_data(input word_t d);
    return {(LINE_B/WORD_B){d}};
  endfunction

  function automatic word_t pick_word(input ldata_t d, input wsel_t w);
    return d[w*WORD_B*8 +: WORD_B*8];
  endfunction

  function automatic be_t pick_be(input lmask_t m, input wsel_t w);
    return m[w*WORD_B +: WORD_B];
  endfunction
endpackage

// File: rtl/wbuf_slot.sv
module wbuf_slot
  import wbuf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr,
  input  logic   wr_new,
  input  line_t  wr_line,
  input  lmask_t wr_bm,
  input  ldata_t wr_bytes,
  input  logic   clr,
  output logic   valid,
  output line_t  line,
  output ldata_t data,
  output lmask_t mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      line  <= '0;
      data  <= '0;
      mask  <= '0;
    end else if (clr) begin
      valid <= 1'b0;
      mask  <= '0;
    end else if (wr) begin
      if (wr_new) begin
        valid <= 1'b1;
        line  <= wr_line;
        mask  <= wr_bm;
      end else begin
        mask  <= mask | wr_bm;
      end
      for (int b = 0; b < LINE_B; b++) begin
        if (wr_bm[b]) data[b*8 +: 8] <= wr_bytes[b*8 +: 8];
      end
    end
  end

  // a slot is never written in the cycle it retires (R10)
  assert_no_write_on_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && wr));

  // merging never touches an empty slot (R3)
  assert_merge_into_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wr_new) |-> valid);
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain (
  input  logic clk,
  input  logic rst_n,
  input  logic has_entry,
  input  logic rd_busy,
  input  logic dr_ready,
  output logic dr_valid,
  output logic pop
);
  logic started;

  assign dr_valid = has_entry && (!rd_busy || started);
  assign pop      = dr_valid && dr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) started <= 1'b0;
    else        started <= dr_valid && !dr_ready;
  end

  assert_hold_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> dr_valid);

  assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !$past(dr_valid)) |-> !rd_busy);
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
  import wbuf_pkg::*;
#(
  parameter int N     = 4,
  parameter int PTR_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_valid [N],
  input  line_t            slot_line  [N],
  input  ldata_t           slot_data  [N],
  input  lmask_t           slot_mask  [N],
  input  logic [PTR_W-1:0] head,
  input  logic             ld_valid,
  input  line_t            ld_line,
  input  wsel_t            ld_word,
  input  be_t              ld_be,
  output logic             ld_hit,
  output logic             ld_stall,
  output word_t            ld_data
);
  logic             match;
  be_t              cov;
  word_t            acc;
  logic [PTR_W-1:0] idx;
  be_t              wm;
  word_t            wd;

  // walk oldest to newest so younger bytes win
  always_comb begin
    match = 1'b0;
    cov   = '0;
    acc   = '0;
    idx   = '0;
    wm    = '0;
    wd    = '0;
    for (int k = 0; k < N; k++) begin
      idx = head + PTR_W'(k);
      if (slot_valid[idx] && slot_line[idx] == ld_line) begin
        match = 1'b1;
        wm = pick_be(slot_mask[idx], ld_word);
        wd = pick_word(slot_data[idx], ld_word);
        for (int b = 0; b < WORD_B; b++) begin
          if (wm[b] && ld_be[b]) begin
            cov[b] = 1'b1;
            acc[b*8 +: 8] = wd[b*8 +: 8];
          end
        end
      end
    end
  end

  assign ld_hit   = ld_valid && match && (cov == ld_be);
  assign ld_stall = ld_valid && match && (cov != ld_be);
  assign ld_data  = ld_valid ? acc : '0;

  assert_hit_stall_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_stall));

  assert_quiet_without_probe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (!ld_hit && !ld_stall && ld_data == '0));
endmodule

// File: rtl/store_merge_buf.sv
module store_merge_buf
  import wbuf_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   st_valid,
  output logic                   st_ready,
  input  logic [ADDR_W-1:0]      st_addr,
  input  logic [WORD_B*8-1:0]    st_data,
  input  logic [WORD_B-1:0]      st_be,
  input  logic                   ld_valid,
  input  logic [ADDR_W-1:0]      ld_addr,
  input  logic [WORD_B-1:0]      ld_be,
  output logic                   ld_hit,
  output logic                   ld_stall,
  output logic [WORD_B*8-1:0]    ld_data,
  input  logic                   rd_busy,
  output logic                   dr_valid,
  input  logic                   dr_ready,
  output logic [LINE_W-1:0]      dr_line,
  output logic [LINE_B*8-1:0]    dr_data,
  output logic [LINE_B-1:0]      dr_mask
);
  localparam int PTR_W = $clog2(ENTRIES);
  localparam int CNT_W = PTR_W + 1;

  logic             slot_valid [ENTRIES];
  line_t            slot_line  [ENTRIES];
  ldata_t           slot_data  [ENTRIES];
  lmask_t           slot_mask  [ENTRIES];

  logic [PTR_W-1:0] head;
  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] tail;
  logic             pop;
  logic             lock;

  line_t            st_line;
  logic             st_open;     // an unlocked slot holds this line
  logic [PTR_W-1:0] st_idx;
  logic             st_fire;
  logic             st_merge;
  logic             st_alloc;
  lmask_t           st_bm;
  ldata_t           st_bytes;
  logic             buf_full;

  assign st_line  = line_of(st_addr);
  assign st_bm    = spread_be(word_of(st_addr), st_be);
  assign st_bytes = spread_data(st_data);
  assign tail     = head + count[PTR_W-1:0];
  assign buf_full = (count == CNT_W'(ENTRIES));
  assign lock     = dr_valid;

  always_comb begin
    st_open = 1'b0;
    st_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (slot_valid[i] && slot_line[i] == st_line &&
          !(lock && PTR_W'(i) == head)) begin
        st_open = 1'b1;
        st_idx  = PTR_W'(i);
      end
    end
  end

  assign st_ready = st_open || !buf_full;
  assign st_fire  = st_valid && st_ready;
  assign st_merge = st_fire && st_open;
  assign st_alloc = st_fire && !st_open;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic wr_g;
    logic clr_g;
    assign wr_g  = (st_merge && st_idx == PTR_W'(g)) || (st_alloc && tail == PTR_W'(g));
    assign clr_g = pop && head == PTR_W'(g);
    wbuf_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_g),
      .wr_new   (st_alloc),
      .wr_line  (st_line),
      .wr_bm    (st_bm),
      .wr_bytes (st_bytes),
      .clr      (clr_g),
      .valid    (slot_valid[g]),
      .line     (slot_line[g]),
      .data     (slot_data[g]),
      .mask     (slot_mask[g])
    );
  end

  wbuf_drain u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .has_entry (count != '0),
    .rd_busy   (rd_busy),
    .dr_ready  (dr_ready),
    .dr_valid  (dr_valid),
    .pop       (pop)
  );

  assign dr_line = slot_line[head];
  assign dr_data = slot_data[head];
  assign dr_mask = slot_mask[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else begin
      if (pop) head <= head + 1'b1;
      count <= count + CNT_W'(st_alloc) - CNT_W'(pop);
    end
  end

  wbuf_fwd #(.N(ENTRIES)) u_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_valid (slot_valid),
    .slot_line  (slot_line),
    .slot_data  (slot_data),
    .slot_mask  (slot_mask),
    .head       (head),
    .ld_valid   (ld_valid),
    .ld_line    (line_of(ld_addr)),
    .ld_word    (word_of(ld_addr)),
    .ld_be      (ld_be),
    .ld_hit     (ld_hit),
    .ld_stall   (ld_stall),
    .ld_data    (ld_data)
  );

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st_alloc |-> !buf_full);

  assert_count_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(ENTRIES));

  assert_offer_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |-> (dr_mask != '0 && slot_valid[head]));

  assert_locked_payload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> ($stable(dr_line) && $stable(dr_mask) && $stable(dr_data)));

  assert_oldest_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (count == $past(count) - CNT_W'(1) + CNT_W'($past(st_alloc))));
endmodule

// File: tb/tb_store_merge_buf.sv
module tb_store_merge_buf;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid;
  logic         st_ready;
  logic [31:0]  st_addr;
  logic [31:0]  st_data;
  logic [3:0]   st_be;
  logic         ld_valid;
  logic [31:0]  ld_addr;
  logic [3:0]   ld_be;
  logic         ld_hit;
  logic         ld_stall;
  logic [31:0]  ld_data;
  logic         rd_busy;
  logic         dr_valid;
  logic         dr_ready;
  logic [26:0]  dr_line;
  logic [255:0] dr_data;
  logic [31:0]  dr_mask;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  store_merge_buf dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data),
    .rd_busy(rd_busy), .dr_valid(dr_valid), .dr_ready(dr_ready),
    .dr_line(dr_line), .dr_data(dr_data), .dr_mask(dr_mask)
  );

  // load probe table: address, enables, expected hit, stall, data
  localparam int NV = 7;
  localparam logic [31:0] V_ADDR [NV] = '{32'h1004, 32'h1008, 32'h1008, 32'h3000,
                                          32'h2000, 32'h100C, 32'h2004};
  localparam logic [3:0]  V_BE   [NV] = '{4'hF, 4'h3, 4'hF, 4'hF, 4'h4, 4'h1, 4'hF};
  localparam logic        V_HIT  [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic        V_STL  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] V_DATA [NV] = '{32'h11225544, 32'h0000CCDD, 32'h0000CCDD,
                                          32'h0, 32'h00FE0000, 32'h0, 32'h0};

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic ready_for(input logic [31:0] a, input logic exp, input string tag);
    @(negedge clk);
    st_addr = a; #1;
    check(tag, 256'(st_ready), 256'(exp));
  endtask

  task automatic probe(input logic [31:0] a, input logic [3:0] be,
                       input logic eh, input logic es, input logic [31:0] ed, input string tag);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_be = be; #1;
    check({tag, " hit"},   256'(ld_hit),   256'(eh));
    check({tag, " stall"}, 256'(ld_stall), 256'(es));
    check({tag, " data"},  256'(ld_data),  256'(ed));
    ld_valid = 1'b0;
  endtask

  task automatic drain_pop(input logic [26:0] eline, input logic [31:0] emask, input string tag);
    @(negedge clk); #1;
    check({tag, " valid"}, 256'(dr_valid), 256'(1));
    check({tag, " line"},  256'(dr_line),  256'(eline));
    check({tag, " mask"},  256'(dr_mask),  256'(emask));
    dr_ready = 1'b1;
    @(posedge clk); #1;
    dr_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_valid = 0; st_addr = 0; st_data = 0; st_be = 0;
    ld_valid = 0; ld_addr = 0; ld_be = 0; rd_busy = 0; dr_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 32'h1004; ld_be = 4'hF; #1;
    check("R1 dr_valid", 256'(dr_valid), 256'(0));
    check("R1 st_ready", 256'(st_ready), 256'(1));
    check("R1 ld_hit",   256'(ld_hit),   256'(0));
    check("R1 ld_stall", 256'(ld_stall), 256'(0));
    ld_valid = 1'b0;

    rd_busy = 1'b1;
    // R2 new line, R3 merge, R4 byte overwrite
    do_store(32'h1004, 32'h11223344, 4'hF);
    do_store(32'h1008, 32'hAABBCCDD, 4'h3);
    do_store(32'h1004, 32'h00005500, 4'h2);
    do_store(32'h2000, 32'hCAFEF00D, 4'hF);

    // table walk: R5 hits, R6 partial, R7 misses
    for (int i = 0; i < NV; i++) begin
      probe(V_ADDR[i], V_BE[i], V_HIT[i], V_STL[i], V_DATA[i], $sformatf("R5/R6/R7 vec%0d", i));
    end

    // R3/R4: only two slots used so far, so two more lines still fit
    ready_for(32'h3000, 1'b1, "R3 room for third line");
    do_store(32'h3000, 32'h33333333, 4'hF);
    ready_for(32'h4000, 1'b1, "R4 room for fourth line");
    do_store(32'h4000, 32'h44444444, 4'hF);
    // R11 full
    ready_for(32'h5000, 1'b0, "R11 full blocks new line");
    ready_for(32'h1010, 1'b1, "R11 full still merges");
    do_store(32'h1010, 32'h77777777, 4'hF);

    // R8 drain waits for idle read side
    @(negedge clk); #1;
    check("R8 no drain while read busy", 256'(dr_valid), 256'(0));
    rd_busy = 1'b0; #1;
    check("R8 offer when idle", 256'(dr_valid), 256'(1));
    check("R2 line",  256'(dr_line), 256'(27'h80));
    check("R3 mask",  256'(dr_mask), 256'(32'h000F03F0));
    check("R4 word1", 256'(dr_data[63:32]),   256'(32'h11225544));
    check("R3 word2", 256'(dr_data[95:64]),   256'(32'h0000CCDD));
    check("R11 word4", 256'(dr_data[159:128]), 256'(32'h77777777));
    @(negedge clk);
    rd_busy = 1'b1; #1;
    check("R8 offer held", 256'(dr_valid), 256'(1));
    check("R8 line held",  256'(dr_line),  256'(27'h80));
    ready_for(32'h1000, 1'b0, "R10 locked head refuses merge when full");

    drain_pop(27'h80, 32'h000F03F0, "R9 first");
    @(negedge clk); #1;
    check("R8 next waits for idle", 256'(dr_valid), 256'(0));
    ready_for(32'h5000, 1'b1, "R11 ready after drain");
    probe(32'h1008, 4'hF, 1'b0, 1'b0, 32'h0, "R6 stall clears after drain");

    rd_busy = 1'b0;
    @(negedge clk); #1;
    check("R2 second data", 256'(dr_data[31:0]), 256'(32'hCAFEF00D));
    drain_pop(27'h100, 32'h0000000F, "R9 second");
    drain_pop(27'h180, 32'h0000000F, "R9 third");
    drain_pop(27'h200, 32'h0000000F, "R9 fourth");
    @(negedge clk); #1;
    check("R9 empty after four", 256'(dr_valid), 256'(0));

    // R10 locked head forces a second slot for the same line
    do_store(32'h6000, 32'h01020304, 4'hF);
    @(negedge clk); #1;
    check("R10 head offered", 256'(dr_valid), 256'(1));
    do_store(32'h6000, 32'h000000A0, 4'h1);
    probe(32'h6000, 4'hF, 1'b1, 1'b0, 32'h010203A0, "R10 newer bytes win");
    @(negedge clk); #1;
    check("R10 old data intact", 256'(dr_data[31:0]), 256'(32'h01020304));
    drain_pop(27'h300, 32'h0000000F, "R10 old slot");
    @(negedge clk); #1;
    check("R10 new byte", 256'(dr_data[7:0]), 256'(8'hA0));
    drain_pop(27'h300, 32'h00000001, "R10 new slot");
    @(negedge clk); #1;
    check("R10 empty", 256'(dr_valid), 256'(0));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule